// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block supplies the status byte a host reads from a flash array while an internal program or erase algorithm is running. A command decoder hands it one pulse per accepted command, and the operation engine reports completion and time-limit overruns. From these it tracks the controller phase and, on every read strobe, says whether the read returns status instead of array data and what that status byte holds. Bits 7, 6, 5, 3 and 2 of the byte carry the progress flags; the remaining bits read 0.

Sector erase uses a collection window. A sector-erase command opens a window of `WIN_CYC` clock cycles, and each further sector-erase command inside it restarts the count and adds its sector to the erase set. When the count runs out the block pulses `erase_go` so that the engine begins erasing. A suspend command, written during the window or during a sector erase, parks the erase. Reads from a sector in the erase set then return status, and reads from any other sector return array data. A byte program may run inside the suspension. A resume command continues the erase.

The controller states are ST_IDLE, ST_PROG, ST_WIN, ST_RUN, ST_SUSP, ST_SUSP_PROG and ST_FAIL. The named transitions are:
- start_prog: ST_IDLE to ST_PROG.
- start_chip: ST_IDLE to ST_RUN.
- open_win: ST_IDLE to ST_WIN.
- restart_win: ST_WIN to ST_WIN.
- abort_win: ST_WIN to ST_IDLE.
- win_expire: ST_WIN to ST_RUN, with `erase_go`.
- suspend: ST_WIN or ST_RUN to ST_SUSP.
- resume: ST_SUSP to ST_RUN.
- susp_prog: ST_SUSP to ST_SUSP_PROG.
- susp_prog_done: ST_SUSP_PROG to ST_SUSP.
- finish: ST_PROG or ST_RUN to ST_IDLE.
- overrun: any busy state to ST_FAIL.

Only reset leaves ST_FAIL.

Top module: `erase_status_gen`

## Requirements
- R1: After reset, and whenever no operation is active, `stat_sel` is 0. `cmd_kind` codes are: 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 any other command.
- R2: While a byte program runs, `stat_sel` is 1 and `stat_byte[7]` is the inverse of the latched `cmd_bit7`. After `op_done`, `stat_sel` returns to 0.
- R3: While a chip or sector erase runs, `stat_sel` is 1 and `stat_byte[7]` is 0. After `op_done`, `stat_sel` returns to 0.
- R4: In every busy state, `stat_byte[6]` inverts after each read strobe and only then. The value seen during a strobe is the value before the flip.
- R5: `op_timeout` during a program or erase sets `stat_byte[5]` to 1. It stays set, with `stat_sel` at 1, through later commands and `op_done` until reset. During a failed program, bit 7 stays inverted.
- R6: A sector-erase command opens a window during which `stat_byte[3]` reads 0. In the last window cycle, `WIN_CYC` clocks after the command edge, `erase_go` is high for one cycle. After that, `stat_byte[3]` reads 1.
- R7: A sector-erase command inside the window restarts the full count and adds its sector. `stat_byte[2]` toggles on reads of selected sectors.
- R8: Any command other than sector erase or suspend inside the window returns the block to idle without `erase_go`.
- R9: A suspend during the window or a sector erase stops the window without `erase_go`. While suspended, reads of a selected sector give `stat_sel`=1, bit 7 = 1, bit 6 = 1 and a toggling bit 2. Reads of other sectors give `stat_sel`=0.
- R10: A program while suspended shows program status on all reads, and its `op_done` returns to suspension. Resume returns to the running erase, with bit 3 = 1.
- R11: While an erase runs, commands other than suspend are ignored, and a chip erase also ignores suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | One-cycle command pulse |
| cmd_kind | input | 3 | Command code (see R1) |
| cmd_sector | input | SW | Sector addressed by the command |
| cmd_bit7 | input | 1 | Bit 7 of the data being programmed |
| op_done | input | 1 | Engine reports operation complete |
| op_timeout | input | 1 | Engine reports time limit exceeded |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_sector | input | SW | Sector of the read address |
| stat_sel | output | 1 | Read returns status instead of array data |
| stat_byte | output | 8 | Status byte for the current read |
| erase_go | output | 1 | One-cycle pulse: collection window closed, erase begins |

## Verification
The hardest situation to reach is a program nested inside a suspended sector erase whose window was restarted. The suspend has to arrive after the restart but before the original expiry, so the stimulus issues a second sector-erase command part way through the window. It then waits past the first deadline and checks that bit 3 is still 0 and that no `erase_go` has appeared. Only then does it suspend, program, and resume. The bench reads the selected and unselected sectors at each stage, so membership of the erase set is seen only through `stat_sel` and bit 2.

// File: rtl/esg_pkg.sv
package esg_pkg;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_PROG      = 3'd1,
        CMD_CHIP_ER   = 3'd2,
        CMD_SECT_ER   = 3'd3,
        CMD_SUSPEND   = 3'd4,
        CMD_RESUME    = 3'd5,
        CMD_OTHER     = 3'd6
    } esg_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROG      = 3'd1,
        ST_WIN       = 3'd2,
        ST_RUN       = 3'd3,
        ST_SUSP      = 3'd4,
        ST_SUSP_PROG = 3'd5,
        ST_FAIL      = 3'd6
    } esg_state_e;

    localparam int BIT_POLL   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;
    localparam int BIT_WINDOW = 3;
    localparam int BIT_SECTOG = 2;

endpackage

// File: rtl/esg_window_timer.sv
module esg_window_timer #(
    parameter int WIN_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WIN_CYC);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end else if (!run) begin
            cnt_q <= '0;
        end
    end

    assign expire = run && (cnt_q == ONE);

endmodule

// File: rtl/esg_sector_mask.sv
module esg_sector_mask #(
    parameter int NSECT = 16,
    parameter int SW    = $clog2(NSECT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set,
    input  logic [SW-1:0] set_idx,
    input  logic [SW-1:0] look_idx,
    output logic          hit
);
    logic [NSECT-1:0] sel_q;

    for (genvar g = 0; g < NSECT; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                sel_q[g] <= 1'b0;
            end else if (set && set_idx == SW'(g)) begin
                sel_q[g] <= 1'b1;
            end
        end
    end

    assign hit = sel_q[look_idx];

endmodule

// File: rtl/esg_toggle.sv
module esg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (flip) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/esg_ctrl.sv
module esg_ctrl
    import esg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_stb,
    input  logic [2:0] cmd_kind,
    input  logic       cmd_bit7,
    input  logic       op_done,
    input  logic       op_timeout,
    input  logic       win_expire,
    output esg_state_e state_q,
    output logic       bit7_q,
    output logic       chip_q,
    output logic       fail_prog_q,
    output logic       mask_set,
    output logic       mask_clr,
    output logic       timer_load,
    output logic       go
);
    esg_state_e state_d;
    esg_cmd_e   kind;
    logic       latch_b7;
    logic       set_chip;
    logic       clr_chip;
    logic       fail_prog_d;

    assign kind = esg_cmd_e'(cmd_kind);

    always_comb begin
        state_d     = state_q;
        latch_b7    = 1'b0;
        set_chip    = 1'b0;
        clr_chip    = 1'b0;
        fail_prog_d = fail_prog_q;
        mask_set    = 1'b0;
        mask_clr    = 1'b0;
        timer_load  = 1'b0;
        go          = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_stb) begin
                    if (kind == CMD_PROG) begin
                        state_d  = ST_PROG;
                        latch_b7 = 1'b1;
                    end else if (kind == CMD_CHIP_ER) begin
                        state_d  = ST_RUN;
                        set_chip = 1'b1;
                    end else if (kind == CMD_SECT_ER) begin
                        state_d    = ST_WIN;
                        clr_chip   = 1'b1;
                        mask_set   = 1'b1;
                        timer_load = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (op_timeout) begin
                    state_d     = ST_FAIL;
                    fail_prog_d = 1'b1;
                end else if (op_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WIN: begin
                if (cmd_stb) begin
                    if (kind == CMD_SECT_ER) begin
                        mask_set   = 1'b1;
                        timer_load = 1'b1;
                    end else if (kind == CMD_SUSPEND) begin
                        state_d = ST_SUSP;
                    end else begin
                        state_d  = ST_IDLE;
                        mask_clr = 1'b1;
                    end
                end else if (win_expire) begin
                    state_d = ST_RUN;
                    go      = 1'b1;
                end
            end
            ST_RUN: begin
                if (op_timeout) begin
                    state_d     = ST_FAIL;
                    fail_prog_d = 1'b0;
                end else if (op_done) begin
                    state_d  = ST_IDLE;
                    mask_clr = 1'b1;
                end else if (cmd_stb && kind == CMD_SUSPEND && !chip_q) begin
                    state_d = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (cmd_stb && kind == CMD_RESUME) begin
                    state_d = ST_RUN;
                end else if (cmd_stb && kind == CMD_PROG) begin
                    state_d  = ST_SUSP_PROG;
                    latch_b7 = 1'b1;
                end
            end
            ST_SUSP_PROG: begin
                if (op_timeout) begin
                    state_d     = ST_FAIL;
                    fail_prog_d = 1'b1;
                end else if (op_done) begin
                    state_d = ST_SUSP;
                end
            end
            ST_FAIL: begin
                state_d = ST_FAIL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bit7_q      <= 1'b0;
            chip_q      <= 1'b0;
            fail_prog_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            fail_prog_q <= fail_prog_d;
            if (latch_b7) begin
                bit7_q <= cmd_bit7;
            end
            if (set_chip) begin
                chip_q <= 1'b1;
            end else if (clr_chip) begin
                chip_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
    import esg_pkg::*;
#(
    parameter int NSECT   = 16,
    parameter int WIN_CYC = 2500,
    parameter int SW      = $clog2(NSECT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_stb,
    input  logic [2:0]    cmd_kind,
    input  logic [SW-1:0] cmd_sector,
    input  logic          cmd_bit7,
    input  logic          op_done,
    input  logic          op_timeout,
    input  logic          rd_stb,
    input  logic [SW-1:0] rd_sector,
    output logic          stat_sel,
    output logic [7:0]    stat_byte,
    output logic          erase_go
);
    esg_state_e state_q;
    logic bit7_q, chip_q, fail_prog_q;
    logic mask_set, mask_clr, timer_load, win_expire;
    logic in_set;
    logic tog6_q, tog2_q;
    logic busy, erase_family;

    esg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_stb     (cmd_stb),
        .cmd_kind    (cmd_kind),
        .cmd_bit7    (cmd_bit7),
        .op_done     (op_done),
        .op_timeout  (op_timeout),
        .win_expire  (win_expire),
        .state_q     (state_q),
        .bit7_q      (bit7_q),
        .chip_q      (chip_q),
        .fail_prog_q (fail_prog_q),
        .mask_set    (mask_set),
        .mask_clr    (mask_clr),
        .timer_load  (timer_load),
        .go          (erase_go)
    );

    esg_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .run    (state_q == ST_WIN),
        .expire (win_expire)
    );

    esg_sector_mask #(.NSECT(NSECT), .SW(SW)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mask_clr),
        .set      (mask_set),
        .set_idx  (cmd_sector),
        .look_idx (rd_sector),
        .hit      (in_set)
    );

    assign busy = (state_q == ST_PROG) || (state_q == ST_WIN) || (state_q == ST_RUN)
               || (state_q == ST_SUSP_PROG) || (state_q == ST_FAIL);
    assign erase_family = (state_q == ST_WIN) || (state_q == ST_RUN)
                       || (state_q == ST_SUSP) || (state_q == ST_SUSP_PROG);

    esg_toggle u_tog6 (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (rd_stb && busy),
        .q     (tog6_q)
    );

    esg_toggle u_tog2 (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (rd_stb && erase_family && in_set),
        .q     (tog2_q)
    );

    always_comb begin
        stat_sel  = 1'b0;
        stat_byte = '0;
        unique case (state_q)
            ST_IDLE: begin
                stat_sel = 1'b0;
            end
            ST_PROG: begin
                stat_sel              = 1'b1;
                stat_byte[BIT_POLL]   = ~bit7_q;
                stat_byte[BIT_TOGGLE] = tog6_q;
                stat_byte[BIT_SECTOG] = 1'b1;
            end
            ST_SUSP_PROG: begin
                stat_sel              = 1'b1;
                stat_byte[BIT_POLL]   = ~bit7_q;
                stat_byte[BIT_TOGGLE] = tog6_q;
                stat_byte[BIT_WINDOW] = 1'b1;
                stat_byte[BIT_SECTOG] = in_set ? tog2_q : 1'b1;
            end
            ST_WIN: begin
                stat_sel              = 1'b1;
                stat_byte[BIT_TOGGLE] = tog6_q;
                stat_byte[BIT_SECTOG] = in_set ? tog2_q : 1'b1;
            end
            ST_RUN: begin
                stat_sel              = 1'b1;
                stat_byte[BIT_TOGGLE] = tog6_q;
                stat_byte[BIT_WINDOW] = 1'b1;
                stat_byte[BIT_SECTOG] = in_set ? tog2_q : 1'b1;
            end
            ST_SUSP: begin
                stat_sel = in_set;
                if (in_set) begin
                    stat_byte[BIT_POLL]   = 1'b1;
                    stat_byte[BIT_TOGGLE] = 1'b1;
                    stat_byte[BIT_SECTOG] = tog2_q;
                end
            end
            ST_FAIL: begin
                stat_sel              = 1'b1;
                stat_byte[BIT_POLL]   = fail_prog_q ? ~bit7_q : 1'b0;
                stat_byte[BIT_TOGGLE] = tog6_q;
                stat_byte[BIT_LIMIT]  = 1'b1;
                stat_byte[BIT_WINDOW] = ~fail_prog_q;
                stat_byte[BIT_SECTOG] = 1'b1;
            end
            default: stat_sel = 1'b0;
        endcase
    end

endmodule

// File: rtl/esg_checker.sv
module esg_checker
    import esg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input esg_state_e state_q,
    input logic       cmd_stb,
    input logic [2:0] cmd_kind,
    input logic       op_done,
    input logic       op_timeout,
    input logic       rd_stb,
    input logic       stat_sel,
    input logic [7:0] stat_byte,
    input logic       erase_go
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !stat_sel);

    // R4
    dq6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && state_q == ST_PROG && !op_done && !op_timeout)
        |=> (stat_byte[6] != $past(stat_byte[6])));

    // R5
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL) |=> (state_q == ST_FAIL && stat_sel && stat_byte[5]));

    // R6
    go_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> (state_q == ST_RUN && !erase_go));

    // R11
    run_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cmd_stb && cmd_kind != 3'd4 && !op_done && !op_timeout)
        |=> (state_q == ST_RUN));

    // R9
    susp_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP) |-> !erase_go);
endmodule

bind erase_status_gen esg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .cmd_stb    (cmd_stb),
    .cmd_kind   (cmd_kind),
    .op_done    (op_done),
    .op_timeout (op_timeout),
    .rd_stb     (rd_stb),
    .stat_sel   (stat_sel),
    .stat_byte  (stat_byte),
    .erase_go   (erase_go)
);

// File: tb/sim_erase_status_gen.sv
module sim_erase_status_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NSECT      = 16;
    localparam int WIN        = 16;
    localparam int SW         = $clog2(NSECT);

    localparam logic [2:0] K_PROG = 3'd1, K_CHIP = 3'd2, K_SECT = 3'd3,
                           K_SUSP = 3'd4, K_RES = 3'd5, K_OTH = 3'd6;

    // vector: {kind[2:0], bit7, expected bit7 of status}
    localparam logic [4:0] VEC [0:3] = '{
        {3'd1, 1'b0, 1'b1},
        {3'd1, 1'b1, 1'b0},
        {3'd2, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_stb = 1'b0;
    logic [2:0] cmd_kind = '0;
    logic [SW-1:0] cmd_sector = '0;
    logic cmd_bit7 = 1'b0;
    logic op_done = 1'b0;
    logic op_timeout = 1'b0;
    logic rd_stb = 1'b0;
    logic [SW-1:0] rd_sector = '0;
    logic stat_sel;
    logic [7:0] stat_byte;
    logic erase_go;

    int total = 0;
    int bad = 0;
    int go_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && erase_go) go_cnt++;

    erase_status_gen #(.NSECT(NSECT), .WIN_CYC(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind),
        .cmd_sector(cmd_sector), .cmd_bit7(cmd_bit7), .op_done(op_done),
        .op_timeout(op_timeout), .rd_stb(rd_stb), .rd_sector(rd_sector),
        .stat_sel(stat_sel), .stat_byte(stat_byte), .erase_go(erase_go)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] k, input logic [SW-1:0] s, input logic b7);
        @(posedge clk); #1;
        cmd_stb = 1'b1; cmd_kind = k; cmd_sector = s; cmd_bit7 = b7;
        @(posedge clk); #1;
        cmd_stb = 1'b0; cmd_kind = '0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1 op_done = 1'b1;
        @(posedge clk); #1 op_done = 1'b0;
    endtask

    task automatic pulse_timeout();
        @(posedge clk); #1 op_timeout = 1'b1;
        @(posedge clk); #1 op_timeout = 1'b0;
    endtask

    task automatic rd(input logic [SW-1:0] s, output logic sel, output logic [7:0] b);
        @(posedge clk); #1;
        rd_stb = 1'b1; rd_sector = s;
        @(negedge clk);
        sel = stat_sel; b = stat_byte;
        @(posedge clk); #1 rd_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic s;
        logic [7:0] b, b2;
        int g0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(0, s, b); chk("R1 sel after reset", {7'b0, s}, 8'h00);

        for (int i = 0; i < 4; i++) begin
            cmd(VEC[i][4:2], 0, VEC[i][1]);
            rd(0, s, b);
            chk(VEC[i][4:2] == K_PROG ? "R2 sel busy" : "R3 sel busy", {7'b0, s}, 8'h01);
            chk(VEC[i][4:2] == K_PROG ? "R2 dq7" : "R3 dq7", {7'b0, b[7]}, {7'b0, VEC[i][0]});
            rd(0, s, b2);
            chk("R4 dq6 flips per read", {7'b0, b2[6]}, {7'b0, ~b[6]});
            repeat (5) @(posedge clk);
            rd(0, s, b);
            chk("R4 dq6 flips once over idle", {7'b0, b[6]}, {7'b0, ~b2[6]});
            pulse_done();
            rd(0, s, b);
            chk(VEC[i][4:2] == K_PROG ? "R2 sel after done" : "R3 sel after done", {7'b0, s}, 8'h00);
        end

        // R6: window then expiry
        g0 = go_cnt;
        cmd(K_SECT, 3, 1'b0);
        repeat (WIN - 2) @(posedge clk);
        rd(3, s, b);
        chk("R6 dq3 low in last window cycle", {7'b0, s, b[3]}, 8'h02);
        chk("R3 dq7 during window", {7'b0, b[7]}, 8'h00);
        rd(3, s, b);
        chk("R6 dq3 high after expiry", {7'b0, b[3]}, 8'h01);
        chk("R6 one erase_go", go_cnt - g0, 1);
        pulse_done();
        rd(3, s, b); chk("R3 idle after erase", {7'b0, s}, 8'h00);

        // R7: restart and sector add
        g0 = go_cnt;
        cmd(K_SECT, 3, 1'b0);
        repeat (8) @(posedge clk);
        cmd(K_SECT, 7, 1'b0);
        repeat (6) @(posedge clk);
        rd(7, s, b);
        chk("R7 window restarted dq3", {7'b0, s, b[3]}, 8'h02);
        chk("R7 no erase_go", go_cnt - g0, 0);
        rd(7, s, b2);
        chk("R7 dq2 toggles on added sector", {7'b0, b2[2]}, {7'b0, ~b[2]});

        // R9: suspend
        cmd(K_SUSP, 0, 1'b0);
        rd(3, s, b);
        chk("R9 suspended sector status", {s, b[7], b[6]}, 8'h07);
        rd(3, s, b2);
        chk("R9 dq2 toggles", {7'b0, b2[2]}, {7'b0, ~b[2]});
        rd(5, s, b); chk("R9 other sector array", {7'b0, s}, 8'h00);
        rd(7, s, b); chk("R7 second sector in set", {7'b0, s}, 8'h01);
        repeat (WIN) @(posedge clk);
        chk("R9 no erase_go while suspended", go_cnt - g0, 0);

        // R10: program inside suspension, then resume
        cmd(K_PROG, 5, 1'b1);
        rd(5, s, b);
        chk("R10 suspend program status", {7'b0, s, b[7]}, 8'h02);
        pulse_done();
        rd(5, s, b); chk("R10 back to suspend", {7'b0, s}, 8'h00);
        cmd(K_RES, 0, 1'b0);
        rd(5, s, b); chk("R10 resumed run", {7'b0, s, b[3]}, 8'h03);

        // R11: ignored commands while running
        cmd(K_OTH, 0, 1'b0);
        cmd(K_SECT, 9, 1'b0);
        rd(9, s, b); chk("R11 run ignores commands", {6'b0, s, b[3]}, 8'h03);
        pulse_done();
        rd(9, s, b); chk("R3 idle after resumed erase", {7'b0, s}, 8'h00);

        // R8: abort the window
        g0 = go_cnt;
        cmd(K_SECT, 2, 1'b0);
        cmd(K_OTH, 0, 1'b0);
        rd(2, s, b); chk("R8 abort to idle", {7'b0, s}, 8'h00);
        repeat (WIN + 2) @(posedge clk);
        chk("R8 no erase_go", go_cnt - g0, 0);

        // R11: chip erase ignores suspend
        cmd(K_CHIP, 0, 1'b0);
        cmd(K_SUSP, 0, 1'b0);
        rd(5, s, b); chk("R11 chip ignores suspend", {6'b0, s, b[7], b[3]}, 8'h05);
        pulse_done();

        // R5: time limit
        cmd(K_PROG, 0, 1'b0);
        pulse_timeout();
        rd(0, s, b); chk("R5 dq5 and dq7", {6'b0, b[5], b[7]}, 8'h03);
        rd(0, s, b2); chk("R4 dq6 toggles in fail", {7'b0, b2[6]}, {7'b0, ~b[6]});
        pulse_done();
        cmd(K_OTH, 0, 1'b0);
        rd(0, s, b); chk("R5 dq5 sticky", {6'b0, s, b[5]}, 8'h03);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        rd(0, s, b); chk("R1 sel after second reset", {7'b0, s}, 8'h00);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule